// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sequences commands for a 32-bit flash bank built from two 16-bit NOR devices wired in parallel. Every command byte is therefore sent twice, once in the low half and once in the high half of the word. A host asks for one of three operations: identify the bank, erase one block, or program one word. The block then carries out the full command exchange on a simple synchronous memory-bus master port. It keeps polling the device status until both devices report ready. It always puts the bank back in read-array mode. It reports a two-bit result code.

Requests use a plain start/busy/done handshake. The memory port is a request/acknowledge channel with back-pressure. The sequencer raises `mem_req` together with `mem_we`, `mem_addr` and `mem_wdata`, and holds all of them unchanged until it sees `mem_ack` high at a clock edge. That edge completes the transfer, and read data is taken from `mem_rdata` at that same edge. The memory side may stall for any number of cycles, and only one transfer is ever outstanding. A poll limit, latched when a request starts, bounds how long the sequencer waits on a device that never becomes ready.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low.
- R2: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged on the next cycle. Read data is taken at the `mem_ack` edge.
- R3: An erase request (`op`=1) writes 0x00200020 and then 0x00D000D0, both to the request address.
- R4: A program request (`op`=2) writes 0x00400040 and then the data word, both to the request address.
- R5: After the two setup writes, the block repeats two steps: it writes 0x00700070 to the request address, then reads that address. It stops when the status word has every bit of 0x00800080 set, so that both devices are ready.
- R6: Once polling ends, whether the devices are ready or the poll limit has run out, the block writes 0x00FF00FF to the operation's address. `done` never comes before that write.
- R7: `result` is 1 (device error) when an erase ends with any bit of 0x00200020 set in the final status, or when a program ends with any bit of 0x00100010 set. A failed program does no read-back.
- R8: A program whose final status is clean reads the address back after read-array is restored. `result` is 2 when the read-back differs from the written data and 0 when it matches.
- R9: Identify (`op`=0) writes 0x00900090 to word 0, reads word 0 and then word 1, and writes 0x00FF00FF to word 0. `result` is 0 when word 0 is 0x00890089 and word 1 is 0x88F388F3 or 0x88F488F4, and 1 otherwise.
- R10: When `poll_limit` status reads in a row show not-ready, the operation ends with `result` 3 (timeout) after the read-array write. A limit of 0 acts as 1.
- R11: A start is accepted only while `busy` is low, and a start with `op`=3 is ignored. `done` is a one-cycle pulse during which `result` is valid and `busy` is still high. `busy` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| op | input | 2 | 0 identify, 1 erase, 2 program, 3 reserved |
| addr | input | ADDR_W | Word address of the target |
| wdata | input | 32 | Word to program |
| poll_limit | input | LIMIT_W | Maximum not-ready status reads |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 device error, 2 verify mismatch, 3 timeout |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Transfer word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes at this edge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
Erase and program are run against a device model that answers busy for a set number of status reads before it reports ready. Error bits are injected into only one half of the status word, which shows that each device is checked on its own. A status with only one half ready must keep polling until the limit, which separates an all-halves ready test from an any-half test. Program is also run with a model that corrupts the stored word, so a verify mismatch can be told apart from a status error. Identify is tried with both accepted device codes and with a rejected one. Starts issued while busy and with the reserved opcode must leave the bus trace unchanged.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  localparam int HALF_W  = 16;
  localparam int NUM_DEV = 2;
  localparam int WORD_W  = NUM_DEV * HALF_W;

  typedef enum logic [1:0] {OP_IDENT = 2'd0, OP_ERASE = 2'd1, OP_PROG = 2'd2, OP_RSVD = 2'd3} op_e;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_DEV = 2'd1, RES_VERIFY = 2'd2, RES_TIMEOUT = 2'd3} res_e;
  typedef enum logic [3:0] {
    STP_IDLE, STP_SETUP, STP_SECOND, STP_SCMD, STP_SREAD,
    STP_RESTORE, STP_VERIFY, STP_IDMAN, STP_IDDEV, STP_DONE
  } step_e;

  function automatic logic [WORD_W-1:0] dup(input logic [7:0] code);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < NUM_DEV; i++) w[i*HALF_W +: 8] = code;
    return w;
  endfunction

  localparam logic [WORD_W-1:0] CMD_ARRAY   = dup(8'hFF);
  localparam logic [WORD_W-1:0] CMD_IDENT   = dup(8'h90);
  localparam logic [WORD_W-1:0] CMD_ESETUP  = dup(8'h20);
  localparam logic [WORD_W-1:0] CMD_CONFIRM = dup(8'hD0);
  localparam logic [WORD_W-1:0] CMD_PSETUP  = dup(8'h40);
  localparam logic [WORD_W-1:0] CMD_STATUS  = dup(8'h70);
  localparam logic [WORD_W-1:0] CMD_CLRSTAT = dup(8'h50);

  localparam logic [WORD_W-1:0] MSK_READY = dup(8'h80);
  localparam logic [WORD_W-1:0] MSK_EERR  = dup(8'h20);
  localparam logic [WORD_W-1:0] MSK_PERR  = dup(8'h10);

  localparam logic [WORD_W-1:0] ID_MAN   = dup(8'h89);
  localparam logic [WORD_W-1:0] ID_DEV_T = {NUM_DEV{16'h88F3}};
  localparam logic [WORD_W-1:0] ID_DEV_B = {NUM_DEV{16'h88F4}};
endpackage

// File: rtl/nor_bus_port.sv
module nor_bus_port
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              go_we_i,
  input  logic [ADDR_W-1:0] go_addr_i,
  input  logic [WORD_W-1:0] go_data_i,
  output logic              fin_o,
  output logic [WORD_W-1:0] rd_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      fin_o     <= 1'b0;
      rd_o      <= '0;
    end else begin
      fin_o <= 1'b0;
      if (go_i && !mem_req) begin
        mem_req   <= 1'b1;
        mem_we    <= go_we_i;
        mem_addr  <= go_addr_i;
        mem_wdata <= go_data_i;
      end else if (mem_req && mem_ack) begin
        mem_req <= 1'b0;
        fin_o   <= 1'b1;
        rd_o    <= mem_rdata;
      end
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !mem_req); // R2
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               bump_i,
  output logic               expire_o
);
  logic [LIMIT_W-1:0] cnt_q, lim_q;
  logic [LIMIT_W:0]   eff, nxt;

  assign eff      = (lim_q == '0) ? (LIMIT_W+1)'(1) : {1'b0, lim_q};
  assign nxt      = {1'b0, cnt_q} + (LIMIT_W+1)'(1);
  assign expire_o = (nxt >= eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (bump_i && !expire_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |-> ({1'b0, cnt_q} < eff)); // R10
endmodule

// File: rtl/nor_status_eval.sv
module nor_status_eval
  import nor_seq_pkg::*;
(
  input  op_e               op_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] man_i,
  output logic              ready_o,
  output logic              dev_fail_o,
  output logic              id_ok_o
);
  logic [NUM_DEV-1:0] half_rdy, half_eerr, half_perr;

  for (genvar h = 0; h < NUM_DEV; h++) begin : g_half
    assign half_rdy[h]  = (word_i[h*HALF_W +: HALF_W] & MSK_READY[h*HALF_W +: HALF_W])
                          == MSK_READY[h*HALF_W +: HALF_W];
    assign half_eerr[h] = |(word_i[h*HALF_W +: HALF_W] & MSK_EERR[h*HALF_W +: HALF_W]);
    assign half_perr[h] = |(word_i[h*HALF_W +: HALF_W] & MSK_PERR[h*HALF_W +: HALF_W]);
  end

  assign ready_o = &half_rdy;

  always_comb begin
    case (op_i)
      OP_ERASE: dev_fail_o = |half_eerr;
      OP_PROG:  dev_fail_o = |half_perr;
      default:  dev_fail_o = 1'b0;
    endcase
  end

  assign id_ok_o = (man_i == ID_MAN) && ((word_i == ID_DEV_T) || (word_i == ID_DEV_B));
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  input  logic [LIMIT_W-1:0] poll_limit,
  output logic               busy,
  output logic               done,
  output logic [1:0]         result,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic               mem_ack,
  input  logic [31:0]        mem_rdata
);
  step_e              step_q;
  logic               wait_q, restored_q;
  op_e                op_q;
  res_e               res_q;
  logic [ADDR_W-1:0]  addr_q, tgt_addr;
  logic [WORD_W-1:0]  data_q, man_q, rd;
  logic               fin, go, acc_we, accept;
  logic [ADDR_W-1:0]  acc_addr;
  logic [WORD_W-1:0]  acc_data;
  logic               ready, dev_fail, id_ok, expire, bump;

  assign accept   = (step_q == STP_IDLE) && start && (op != OP_RSVD);
  assign busy     = (step_q != STP_IDLE);
  assign done     = (step_q == STP_DONE);
  assign result   = res_q;
  assign go       = busy && !done && !wait_q;
  assign tgt_addr = (op_q == OP_IDENT) ? '0 : addr_q;
  assign bump     = fin && (step_q == STP_SREAD) && !ready;

  always_comb begin
    acc_we   = 1'b1;
    acc_addr = tgt_addr;
    acc_data = CMD_ARRAY;
    case (step_q)
      STP_SETUP: acc_data = (op_q == OP_ERASE) ? CMD_ESETUP :
                            (op_q == OP_PROG)  ? CMD_PSETUP : CMD_IDENT;
      STP_SECOND: acc_data = (op_q == OP_ERASE) ? CMD_CONFIRM : data_q;
      STP_SCMD:   acc_data = CMD_STATUS;
      STP_SREAD, STP_VERIFY, STP_IDMAN: acc_we = 1'b0;
      STP_IDDEV: begin
        acc_we   = 1'b0;
        acc_addr = ADDR_W'(1);
      end
      default: acc_data = CMD_ARRAY;
    endcase
  end

  nor_bus_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .go_i(go), .go_we_i(acc_we), .go_addr_i(acc_addr), .go_data_i(acc_data),
    .fin_o(fin), .rd_o(rd),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  nor_poll_timer #(.LIMIT_W(LIMIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .limit_i(poll_limit),
    .bump_i(bump), .expire_o(expire)
  );

  nor_status_eval u_eval (
    .op_i(op_q), .word_i(rd), .man_i(man_q),
    .ready_o(ready), .dev_fail_o(dev_fail), .id_ok_o(id_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q     <= STP_IDLE;
      wait_q     <= 1'b0;
      restored_q <= 1'b0;
      op_q       <= OP_IDENT;
      res_q      <= RES_OK;
      addr_q     <= '0;
      data_q     <= '0;
      man_q      <= '0;
    end else begin
      case (step_q)
        STP_IDLE: if (accept) begin
          op_q       <= op_e'(op);
          addr_q     <= addr;
          data_q     <= wdata;
          res_q      <= RES_OK;
          restored_q <= 1'b0;
          wait_q     <= 1'b0;
          step_q     <= STP_SETUP;
        end
        STP_DONE: step_q <= STP_IDLE;
        default: begin
          if (!wait_q) begin
            wait_q <= 1'b1;
          end else if (fin) begin
            wait_q <= 1'b0;
            if (mem_we && mem_wdata == CMD_ARRAY) restored_q <= 1'b1;
            case (step_q)
              STP_SETUP:  step_q <= (op_q == OP_IDENT) ? STP_IDMAN : STP_SECOND;
              STP_SECOND: step_q <= STP_SCMD;
              STP_SCMD:   step_q <= STP_SREAD;
              STP_SREAD: begin
                if (ready) begin
                  res_q  <= dev_fail ? RES_DEV : RES_OK;
                  step_q <= STP_RESTORE;
                end else if (expire) begin
                  res_q  <= RES_TIMEOUT;
                  step_q <= STP_RESTORE;
                end else begin
                  step_q <= STP_SCMD;
                end
              end
              STP_IDMAN: begin
                man_q  <= rd;
                step_q <= STP_IDDEV;
              end
              STP_IDDEV: begin
                res_q  <= id_ok ? RES_OK : RES_DEV;
                step_q <= STP_RESTORE;
              end
              STP_RESTORE: step_q <= (op_q == OP_PROG && res_q == RES_OK) ? STP_VERIFY : STP_DONE;
              STP_VERIFY: begin
                res_q  <= (rd == data_q) ? RES_OK : RES_VERIFY;
                step_q <= STP_DONE;
              end
              default: step_q <= STP_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !busy && !done && !mem_req); // R1
  AST_DONE_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> restored_q); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(op_q) && $stable(addr_q) && $stable(data_q)); // R11
  AST_VERIFY_PROG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    step_q == STP_VERIFY |-> op_q == OP_PROG && res_q == RES_OK); // R8
  AST_RSVD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && op == OP_RSVD |=> !busy); // R11
endmodule

// File: tb/nor_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [1:0]  op = 0;
  logic [19:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [15:0] poll_limit = 16'd100;
  logic        busy, done, mem_req, mem_we;
  logic [1:0]  result;
  logic [19:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = 0;

  always #4 clk = ~clk;

  nor_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .poll_limit(poll_limit), .busy(busy), .done(done), .result(result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  // device model configuration
  int          lat = 0, busy_cfg = 0, wcnt = 0, busy_left = 0, mode = 0;
  bit          forever_busy = 0, erase_arm = 0, prog_arm = 0;
  logic [31:0] nr_val = 0, err_val = 0, corrupt = 0, dev_code = 32'h88F488F4;
  logic [31:0] arr [16];
  // bus trace
  logic        lg_we [128];
  logic [19:0] lg_a  [128];
  logic [31:0] lg_d  [128];
  int          lg_n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0;
      wcnt = 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_ack <= 1;
        if (lg_n < 128) begin
          lg_we[lg_n] = mem_we; lg_a[lg_n] = mem_addr; lg_d[lg_n] = mem_wdata; lg_n++;
        end
        if (mem_we) begin
          if (prog_arm) begin
            prog_arm = 0; arr[mem_addr[3:0]] = mem_wdata ^ corrupt; busy_left = busy_cfg; mode = 2;
          end else begin
            case (mem_wdata)
              32'h00FF00FF: begin mode = 0; erase_arm = 0; end
              32'h00900090: mode = 1;
              32'h00200020: erase_arm = 1;
              32'h00D000D0: if (erase_arm) begin
                erase_arm = 0; arr[mem_addr[3:0]] = 32'hFFFFFFFF; busy_left = busy_cfg; mode = 2;
              end
              32'h00400040: prog_arm = 1;
              32'h00700070: mode = 2;
              default: ;
            endcase
          end
        end else begin
          case (mode)
            0: mem_rdata <= arr[mem_addr[3:0]];
            1: mem_rdata <= (mem_addr == 0) ? 32'h00890089 : (mem_addr == 1) ? dev_code : 32'h0;
            default: begin
              if (forever_busy || busy_left > 0) begin
                if (busy_left > 0) busy_left--;
                mem_rdata <= nr_val | err_val;
              end else mem_rdata <= 32'h00800080 | err_val;
            end
          endcase
        end
      end else wcnt++;
    end else mem_ack <= 0;
  end

  // bus hold monitor (R2)
  int hold_viol = 0;
  logic p_req = 0, p_ack = 0, p_we = 0;
  logic [19:0] p_a = 0;
  logic [31:0] p_d = 0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack &&
        !(mem_req && mem_we == p_we && mem_addr == p_a && mem_wdata == p_d)) hold_viol++;
    p_req = mem_req; p_ack = mem_ack; p_we = mem_we; p_a = mem_addr; p_d = mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int cnt_w(input logic [31:0] d);
    int n = 0;
    for (int i = 0; i < lg_n; i++) if (lg_we[i] && lg_d[i] == d) n++;
    return n;
  endfunction

  function automatic int cnt_r();
    int n = 0;
    for (int i = 0; i < lg_n; i++) if (!lg_we[i]) n++;
    return n;
  endfunction

  task automatic wait_done(output logic [1:0] r);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL R11 actual=no_done expected=done");
    end
    r = result;
    @(negedge clk);
  endtask

  task automatic run_op(input logic [1:0] o, input logic [19:0] a, input logic [31:0] d,
                        input logic [15:0] lim, output logic [1:0] r);
    @(negedge clk);
    lg_n = 0;
    start = 1; op = o; addr = a; wdata = d; poll_limit = lim;
    @(negedge clk);
    start = 0;
    wait_done(r);
  endtask

  task automatic model_cfg(input int l, input int b, input bit fb, input logic [31:0] nr,
                           input logic [31:0] e, input logic [31:0] c);
    lat = l; busy_cfg = b; forever_busy = fb; nr_val = nr; err_val = e; corrupt = c;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 mem_req", mem_req, 0);
  endtask

  task automatic t_ident();
    logic [1:0] r;
    model_cfg(0, 0, 0, 0, 0, 0);
    dev_code = 32'h88F488F4;
    run_op(2'd0, 20'h55, 0, 16'd10, r);
    chk("R9 ident bottom ok", r, 0);
    chk("R9 first write", lg_d[0], 32'h00900090);
    chk("R9 first addr", lg_a[0], 0);
    chk("R9 read word1 addr", {lg_we[2], lg_a[2]}, {1'b0, 20'd1});
    chk("R6 ident restore", {lg_we[lg_n-1], lg_a[lg_n-1], lg_d[lg_n-1]}, {1'b1, 20'd0, 32'h00FF00FF});
    chk("R11 done pulse", {done, busy}, 0);
    dev_code = 32'h88F388F3;
    run_op(2'd0, 0, 0, 16'd10, r);
    chk("R9 ident top ok", r, 0);
    dev_code = 32'h88F188F1;
    run_op(2'd0, 0, 0, 16'd10, r);
    chk("R9 ident rejected", r, 1);
  endtask

  task automatic t_erase();
    logic [1:0] r;
    model_cfg(1, 3, 0, 0, 0, 0);
    arr[5] = 32'h0;
    run_op(2'd1, 20'd5, 0, 16'd100, r);
    chk("R3 erase ok", r, 0);
    chk("R3 setup", {lg_a[0], lg_d[0]}, {20'd5, 32'h00200020});
    chk("R3 confirm", {lg_a[1], lg_d[1]}, {20'd5, 32'h00D000D0});
    chk("R5 status writes", cnt_w(32'h00700070), 4);
    chk("R6 erase restore", {lg_we[lg_n-1], lg_a[lg_n-1], lg_d[lg_n-1]}, {1'b1, 20'd5, 32'h00FF00FF});
    chk("R3 entries", lg_n, 11);
    chk("R3 block erased", arr[5], 32'hFFFFFFFF);
    model_cfg(0, 1, 0, 0, 32'h00000020, 0);
    run_op(2'd1, 20'd6, 0, 16'd100, r);
    chk("R7 erase error low half", r, 1);
  endtask

  task automatic t_timeout();
    logic [1:0] r;
    model_cfg(2, 0, 1, 32'h00000080, 0, 0);
    run_op(2'd1, 20'd3, 0, 16'd5, r);
    chk("R10 half ready times out", r, 3);
    chk("R5 polls until limit", cnt_w(32'h00700070), 5);
    chk("R6 restore after timeout", {lg_we[lg_n-1], lg_d[lg_n-1]}, {1'b1, 32'h00FF00FF});
    model_cfg(0, 0, 1, 0, 0, 0);
    run_op(2'd2, 20'd3, 32'hA5A5A5A5, 16'd0, r);
    chk("R10 limit zero", r, 3);
    chk("R10 single poll", cnt_w(32'h00700070), 1);
  endtask

  task automatic t_prog();
    logic [1:0] r;
    model_cfg(1, 2, 0, 0, 0, 0);
    run_op(2'd2, 20'd7, 32'h12345678, 16'd50, r);
    chk("R8 program ok", r, 0);
    chk("R4 setup", {lg_a[0], lg_d[0]}, {20'd7, 32'h00400040});
    chk("R4 data", {lg_we[1], lg_a[1], lg_d[1]}, {1'b1, 20'd7, 32'h12345678});
    chk("R8 verify read last", {lg_we[lg_n-1], lg_a[lg_n-1]}, {1'b0, 20'd7});
    chk("R6 restore before verify", lg_d[lg_n-2], 32'h00FF00FF);
    model_cfg(0, 1, 0, 0, 32'h00100000, 0);
    run_op(2'd2, 20'd8, 32'h1, 16'd50, r);
    chk("R7 program error high half", r, 1);
    chk("R7 no read-back", {lg_we[lg_n-1], lg_d[lg_n-1]}, {1'b1, 32'h00FF00FF});
    model_cfg(0, 1, 0, 0, 0, 32'h00000100);
    run_op(2'd2, 20'd9, 32'hCAFEF00D, 16'd50, r);
    chk("R8 verify mismatch", r, 2);
  endtask

  task automatic t_ignore();
    logic [1:0] r;
    int dones = 0;
    model_cfg(0, 20, 0, 0, 0, 0);
    @(negedge clk);
    lg_n = 0;
    start = 1; op = 2'd1; addr = 20'd2; poll_limit = 16'd100;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    start = 1; op = 2'd2; addr = 20'd4; wdata = 32'h0;
    @(negedge clk);
    start = 0;
    wait_done(r);
    chk("R11 busy start ignored", r, 0);
    chk("R11 no program setup", cnt_w(32'h00400040), 0);
    chk("R11 stayed on addr", lg_a[lg_n-1], 20'd2);
    start = 1; op = 2'd3;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 10; i++) begin
      if (busy || mem_req || done) dones++;
      @(negedge clk);
    end
    chk("R11 reserved op ignored", dones, 0);
    chk("R2 bus hold", hold_viol, 0);
    chk("R2 read count sane", cnt_r() > 0, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) arr[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ident();
    t_erase();
    t_timeout();
    t_prog();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule